// File: doc/BRIEF.md
# UART Receive Buffer with Threshold Interrupt

This block holds characters received by a UART-style peripheral until software reads them. Each stored entry is a 12-bit word: the character plus four error flags. A mode input selects the behaviour. In FIFO mode the buffer is a 16-entry circular queue. In single mode it is one holding register. Any change of the mode input empties the buffer.

Characters come from one of two sources:
- the external receiver, when loopback is off;
- the transmitter, when loopback is on. In this case the external input, including its break events, is ignored.

A read strobe removes the head entry and loads its error flags into a sticky status register. A separate clear strobe zeroes that register. The block reports the following on its outputs:
- empty and full flags;
- the free space available to the upstream receiver;
- a latched receive interrupt level. It is set when a push brings the fill level to the trigger level. It is cleared when a read leaves the fill level one below that level.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, the block is in single mode with zero entries. rx_empty is 1, rx_full is 0, free_cnt is 1, rx_irq is 0 and rx_status is 0.
- R2: In FIFO mode, entries leave in the order they arrived. rd_word always shows the head entry. An external character is stored as {overrun[11], break[10], parity[9], framing[8], data[7:0]}, with bits 11 and 10 at 0.
- R3: The effective capacity is DEPTH (16) in FIFO mode and 1 in single mode. rx_full is 1 exactly when the entry count equals the effective capacity. free_cnt equals the effective capacity minus the count.
- R4: A push arriving while the buffer is full is dropped. Instead, bit 11 (overrun) of the most recently stored entry is set.
- R5: In single mode, one push fills the buffer. A second push is dropped and marks the held entry as overrun.
- R6: rx_irq rises on the cycle after a push that brings the count to the trigger level (1). It stays set while entries remain. It falls after a read that leaves the count one below the trigger level.
- R7: A read while empty leaves the count and read position unchanged. rd_word keeps showing the stale word at the read position, and that word's flags are still copied to rx_status. Such a read also clears rx_irq.
- R8: Each accepted read loads bits [11:8] of the head word into rx_status as {overrun, break, parity, framing}. A stat_clr strobe zeroes rx_status.
- R9: A change of fifo_mode empties the buffer and resets the read position to 0. Pushes and reads in that cycle are discarded. rx_irq is left unchanged.
- R10: A flush strobe empties the buffer in the same way as a mode change.
- R11: With loop_en at 1, ext_push and ext_brk are ignored, and each tx_push stores {4'b0000, tx_data}. With loop_en at 0, tx_push and tx_brk are ignored.
- R12: A break event from the active source (ext_brk, or tx_brk in loopback) stores the word 12'h400. If a character push from the same source arrives in the same cycle, the break word wins and the character is lost.
- R13: When a read and a push fall in the same cycle, the read is applied first. At full, the push is therefore accepted without overrun. At empty, the count becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1: 16-entry FIFO, 0: single holding register |
| loop_en | input | 1 | Loopback enable: takes input from the transmitter |
| flush | input | 1 | Empty the buffer |
| ext_push | input | 1 | External receiver has a character |
| ext_data | input | 8 | External character |
| ext_ferr | input | 1 | Framing error of the external character |
| ext_perr | input | 1 | Parity error of the external character |
| ext_brk | input | 1 | Line break detected on the external input |
| tx_push | input | 1 | Transmitter sent a character (loopback) |
| tx_data | input | 8 | Transmitted character |
| tx_brk | input | 1 | Transmit break was switched on (loopback) |
| pop | input | 1 | Data register read strobe |
| stat_clr | input | 1 | Receive status register write strobe |
| rd_word | output | 12 | Head entry |
| rx_status | output | 4 | Sticky flags {overrun, break, parity, framing} |
| rx_empty | output | 1 | Buffer empty |
| rx_full | output | 1 | Buffer full |
| free_cnt | output | 5 | Free entries |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
A read and a push can land on the same edge. The block resolves them read-first, and that ordering decides both the fill level and the interrupt level. The bench provokes the collision twice: once on an empty buffer, where the count must become 1 and rx_irq must end set, and once on a full buffer, where no overrun may appear and the new word must queue behind the survivors. It judges the outcome through free_cnt, rx_full, rx_irq and the order of the words read afterwards.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fifo_mode,
  input  logic                         loop_en,
  input  logic                         flush,
  input  logic                         ext_push,
  input  logic [7:0]                   ext_data,
  input  logic                         ext_ferr,
  input  logic                         ext_perr,
  input  logic                         ext_brk,
  input  logic                         tx_push,
  input  logic [7:0]                   tx_data,
  input  logic                         tx_brk,
  input  logic                         pop,
  input  logic                         stat_clr,
  output logic [11:0]                  rd_word,
  output logic [3:0]                   rx_status,
  output logic                         rx_empty,
  output logic                         rx_full,
  output logic [$clog2(DEPTH):0]       free_cnt,
  output logic                         rx_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] TRIG_C = CW'(TRIG);
  localparam logic [11:0] BRK_WORD = 12'h400;

  logic [11:0]   mem [DEPTH];
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] cnt;
  logic          mode_q;
  logic [3:0]    stat_q;
  logic          irq_q;

  wire [AW-1:0] pmask     = mode_q ? AW'(DEPTH - 1) : '0;
  wire [CW-1:0] eff_depth = mode_q ? CW'(DEPTH) : CW'(1);
  wire          flushing  = flush | (fifo_mode != mode_q);

  logic        src_chr, src_brk;
  logic [11:0] in_word;
  always_comb begin
    if (loop_en) begin
      src_chr = tx_push;
      src_brk = tx_brk;
      in_word = {4'b0000, tx_data};
    end else begin
      src_chr = ext_push;
      src_brk = ext_brk;
      in_word = {2'b00, ext_perr, ext_ferr, ext_data};
    end
    if (src_brk) in_word = BRK_WORD;
  end

  wire           do_pop   = pop & ~flushing;
  wire           pop_real = do_pop & (cnt != '0);
  wire [CW-1:0]  cnt_a    = cnt - CW'(pop_real);
  wire [AW-1:0]  ptr_a    = pop_real ? ((rd_ptr + 1'b1) & pmask) : rd_ptr;
  wire           do_push  = (src_chr | src_brk) & ~flushing;
  wire           fits     = cnt_a != eff_depth;
  wire [AW-1:0]  wr_slot  = (ptr_a + cnt_a[AW-1:0]) & pmask;
  wire [AW-1:0]  ovr_slot = (ptr_a + cnt_a[AW-1:0] - 1'b1) & pmask;
  wire [CW-1:0]  cnt_n    = cnt_a + CW'(do_push & fits);

  logic irq_n;
  always_comb begin
    irq_n = irq_q;
    if (do_pop && (cnt_a + CW'(1)) == TRIG_C) irq_n = 1'b0;
    if (do_push && fits && cnt_n == TRIG_C) irq_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      mode_q <= 1'b0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (flushing) begin
        rd_ptr <= '0;
        cnt    <= '0;
        mode_q <= fifo_mode;
      end else begin
        rd_ptr <= ptr_a;
        cnt    <= cnt_n;
        irq_q  <= irq_n;
        if (do_push) begin
          if (fits) mem[wr_slot] <= in_word;
          else      mem[ovr_slot][11] <= 1'b1;
        end
      end
      if (do_pop)        stat_q <= mem[rd_ptr][11:8];
      else if (stat_clr) stat_q <= '0;
    end
  end

  assign rd_word   = mem[rd_ptr];
  assign rx_status = stat_q;
  assign rx_empty  = cnt == '0;
  assign rx_full   = cnt == eff_depth;
  assign free_cnt  = eff_depth - cnt;
  assign rx_irq    = irq_q;

  // R3
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_empty && rx_full));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= eff_depth);

  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> cnt == TRIG_C);

  // R9
  mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode != mode_q) |=> (rx_empty && rd_ptr == '0 && mode_q == $past(fifo_mode)));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && rx_empty && !(src_chr || src_brk) && !flushing) |=> (rx_empty && $stable(rd_ptr)));

  // R11
  loop_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && !tx_push && !tx_brk && !pop && !flushing) |=> $stable(cnt));
endmodule

// File: tb/uart_rx_fifo_tb.sv
`timescale 1ns/1ps
module uart_rx_fifo_tb;
  logic clk = 0, rst_n = 0;
  logic fifo_mode = 0, loop_en = 0, flush = 0;
  logic ext_push = 0, ext_ferr = 0, ext_perr = 0, ext_brk = 0;
  logic [7:0] ext_data = 0, tx_data = 0;
  logic tx_push = 0, tx_brk = 0, pop = 0, stat_clr = 0;
  logic [11:0] rd_word;
  logic [3:0] rx_status;
  logic rx_empty, rx_full, rx_irq;
  logic [4:0] free_cnt;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  uart_rx_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .loop_en(loop_en), .flush(flush),
    .ext_push(ext_push), .ext_data(ext_data), .ext_ferr(ext_ferr), .ext_perr(ext_perr),
    .ext_brk(ext_brk), .tx_push(tx_push), .tx_data(tx_data), .tx_brk(tx_brk),
    .pop(pop), .stat_clr(stat_clr), .rd_word(rd_word), .rx_status(rx_status),
    .rx_empty(rx_empty), .rx_full(rx_full), .free_cnt(free_cnt), .rx_irq(rx_irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [11:0] xw(logic [7:0] d, logic fe, logic pe);
    return {2'b00, pe, fe, d};
  endfunction

  task automatic push_ext(logic [7:0] d, logic fe, logic pe);
    ext_push = 1; ext_data = d; ext_ferr = fe; ext_perr = pe;
    tick();
    ext_push = 0; ext_ferr = 0; ext_perr = 0;
  endtask

  task automatic do_pop();
    pop = 1; tick(); pop = 0;
  endtask

  task automatic t_reset();
    chk("R1 empty", rx_empty, 1);
    chk("R1 full", rx_full, 0);
    chk("R1 free", free_cnt, 1);
    chk("R1 irq", rx_irq, 0);
    chk("R1 status", rx_status, 0);
  endtask

  task automatic t_fifo_order();
    fifo_mode = 1; tick();
    chk("R9 free after mode", free_cnt, 16);
    for (int i = 0; i < 16; i++) begin
      push_ext(8'(i * 3 + 1), i == 2, i == 0);
      if (i == 0) chk("R6 irq set", rx_irq, 1);
    end
    chk("R3 full", rx_full, 1);
    chk("R3 free zero", free_cnt, 0);
    push_ext(8'hAA, 0, 0);
    chk("R4 still full", free_cnt, 0);
    for (int i = 0; i < 16; i++) begin
      logic [11:0] e;
      e = xw(8'(i * 3 + 1), i == 2, i == 0);
      if (i == 15) e[11] = 1'b1;
      chk(i == 15 ? "R4 overrun mark" : "R2 order", rd_word, e);
      do_pop();
      if (i == 0) chk("R6 irq held", rx_irq, 1);
      if (i == 2) begin
        chk("R8 status framing", rx_status, 4'b0001);
        stat_clr = 1; tick(); stat_clr = 0;
        chk("R8 status cleared", rx_status, 0);
      end
    end
    chk("R3 empty", rx_empty, 1);
    chk("R6 irq cleared", rx_irq, 0);
    chk("R7 stale word", rd_word, xw(8'h01, 0, 1));
    do_pop();
    chk("R7 stale kept", rd_word, xw(8'h01, 0, 1));
    chk("R7 count kept", free_cnt, 16);
    chk("R7 status copy", rx_status, 4'b0010);
  endtask

  task automatic t_simul();
    ext_push = 1; ext_data = 8'hA0; pop = 1; tick();
    ext_push = 0; pop = 0;
    chk("R13 empty collision count", free_cnt, 15);
    chk("R13 empty collision irq", rx_irq, 1);
    chk("R13 head", rd_word, 12'h0A0);
    for (int i = 1; i < 16; i++) push_ext(8'(8'hB0 + i), 0, 0);
    chk("R13 full before", rx_full, 1);
    ext_push = 1; ext_data = 8'hC0; pop = 1; tick();
    ext_push = 0; pop = 0;
    chk("R13 full collision", rx_full, 1);
    chk("R13 new head", rd_word, 12'h0B1);
    for (int i = 1; i < 16; i++) do_pop();
    chk("R13 tail no overrun", rd_word, 12'h0C0);
    flush = 1; tick(); flush = 0;
    chk("R10 flushed", free_cnt, 16);
    chk("R10 irq kept", rx_irq, 1);
    do_pop();
    chk("R7 empty pop clears irq", rx_irq, 0);
  endtask

  task automatic t_single();
    fifo_mode = 0; tick();
    chk("R5 free one", free_cnt, 1);
    push_ext(8'h11, 0, 0);
    chk("R5 full", rx_full, 1);
    chk("R5 free zero", free_cnt, 0);
    push_ext(8'h22, 0, 0);
    chk("R5 overrun", rd_word, 12'h811);
    do_pop();
    chk("R5 empty", rx_empty, 1);
    chk("R8 overrun status", rx_status, 4'b1000);
    push_ext(8'h33, 0, 0);
    fifo_mode = 1; ext_push = 1; ext_data = 8'h44; tick(); ext_push = 0;
    chk("R9 mode flush", free_cnt, 16);
    chk("R9 irq kept", rx_irq, 1);
  endtask

  task automatic t_loop();
    loop_en = 1;
    ext_push = 1; ext_data = 8'h55; ext_brk = 1; tick();
    ext_push = 0; ext_brk = 0;
    chk("R11 ext ignored", rx_empty, 1);
    tx_push = 1; tx_data = 8'h3C; tick(); tx_push = 0;
    chk("R11 tx looped", rd_word, 12'h03C);
    tx_brk = 1; tick(); tx_brk = 0;
    chk("R12 loop break stored", free_cnt, 14);
    do_pop();
    chk("R12 break word", rd_word, 12'h400);
    do_pop();
    chk("R12 break status", rx_status, 4'b0100);
    loop_en = 0;
    tx_push = 1; tx_data = 8'h66; tick(); tx_push = 0;
    chk("R11 tx ignored", rx_empty, 1);
    ext_push = 1; ext_data = 8'h77; ext_brk = 1; tick();
    ext_push = 0; ext_brk = 0;
    chk("R12 priority count", free_cnt, 15);
    chk("R12 priority word", rd_word, 12'h400);
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset();
    t_fifo_order();
    t_simul();
    t_single();
    t_loop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule